// File: doc/BRIEF.md
# Decode-Stage Load-Use Stall and Branch Flush Controller

This block is the hazard control for the fetch and decode stages of a five-stage in-order pipeline. It has two jobs. The first is to spot an instruction in decode that needs a register still being loaded by the instruction one stage ahead. When it sees one, it freezes the program counter and the fetch/decode register for one cycle and zeroes the control word of the instruction in decode, so that a bubble moves down the pipeline in its place. The second is to resolve equal-compare branches in decode. It computes the branch target, redirects the next PC and clears the one wrongly fetched instruction, so a taken branch costs a single cycle. Fetch otherwise assumes branches are not taken.

All pins are plain control and data levels; no pin carries a handshake. The enables, the zeroing select, the flush and the redirect select are combinational from the current inputs. The only state is one bit that remembers a stall issued in the previous cycle. The surrounding pipeline registers, register file, ALU, memories and forwarding network are outside the block.

Top module: `hzc_ctrl`

## Requirements
- R1: The decode instruction word uses bits [25:21] as its first source register and bits [20:16] as its second. A stall is raised when `idex_mem_read` is 1 and `idex_rt` equals either of these fields. Register number 0 is not exempt.
- R2: In a stall cycle `ctrl_zero_sel` is 1 and both `pc_write_en` and `ifid_write_en` are 0. In every other cycle `ctrl_zero_sel` is 0 and both enables are 1.
- R3: A stall lasts exactly one cycle. In the cycle after a stall no stall is raised, whatever the ID/EX inputs are. In the cycle after that, a stall can be raised again.
- R4: The decode instruction is a branch when bits [31:26] equal `BR_OP` (default 6'b000100). The branch is taken when `rdata_a` equals `rdata_b`. Any other opcode never redirects the PC.
- R5: `next_pc` is always `ifid_pc_plus4` plus the sign-extended bits [15:0] of the instruction shifted left by two, wrapping modulo 2^ADDR_W.
- R6: When a branch is taken and there is no stall, `next_pc_sel` and `ifid_flush` are both 1 in that same cycle. Otherwise both are 0, so fetch falls through.
- R7: A stall overrides a taken branch: in a stall cycle `next_pc_sel` and `ifid_flush` are 0. The held branch is resolved in the following cycle from the inputs present then.
- R8: While `rst_n` is low, no stall, flush or redirect is signalled, and the stall history is cleared. The first cycle after reset can therefore stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ifid_instr | input | 32 | Instruction word held in the fetch/decode register |
| ifid_pc_plus4 | input | ADDR_W | Address of the decode instruction plus four |
| idex_mem_read | input | 1 | Instruction in the execute stage reads memory |
| idex_rt | input | 5 | Destination register of the instruction in the execute stage |
| rdata_a | input | DATA_W | Register value read for the first source field |
| rdata_b | input | DATA_W | Register value read for the second source field |
| pc_write_en | output | 1 | PC may load a new value |
| ifid_write_en | output | 1 | Fetch/decode register may load |
| ctrl_zero_sel | output | 1 | Replace the decode control word with zeros |
| ifid_flush | output | 1 | Load an all-zero word (a no-op) into the fetch/decode register |
| next_pc | output | ADDR_W | Branch target address |
| next_pc_sel | output | 1 | PC takes `next_pc` instead of the sequential address |

## Verification
The bench matches the execute-stage destination against each source field separately, and also with register 0. A design that compared only one field, or that skipped register 0, would let a dependent instruction read a stale value. It holds a load-use pattern steady over several cycles to confirm that the stall alternates and never sticks. A design without the stall history would deadlock the pipeline.

It also drives a taken branch together with a stall and then releases the stall. A design with the wrong priority would flush the instruction it was told to hold, or lose the branch. Target checks cover negative offsets and address wrap-around, which a zero-extending or non-shifting adder would get wrong.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int REG_W   = 5;
  localparam int IMM_W   = 16;

  // The field boundaries matter: the register decoder and the branch
  // logic depend on them.
  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] src1;
    logic [REG_W-1:0] src2;
    logic [IMM_W-1:0] imm;
  } dec_word_t;

  typedef enum logic {
    NPC_FALLTHRU = 1'b0,
    NPC_REDIRECT = 1'b1
  } npc_sel_e;
endpackage

// File: rtl/hzc_loaduse.sv
module hzc_loaduse
  import hzc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] dec_src1,
  input  logic [REG_W-1:0] dec_src2,
  input  logic             ex_mem_read,
  input  logic [REG_W-1:0] ex_dest,
  output logic             stall
);
  logic hit_src1;
  logic hit_src2;
  logic dep_hit;
  logic stalled_q;

  assign hit_src1 = (ex_dest == dec_src1);
  assign hit_src2 = (ex_dest == dec_src2);
  assign dep_hit  = ex_mem_read && (hit_src1 || hit_src2);

  // The cycle after a stall, execute holds the bubble this block inserted,
  // so whatever the ID/EX inputs say, no second stall is issued.
  assign stall = rst_n && dep_hit && !stalled_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stalled_q <= 1'b0;
    else        stalled_q <= stall;
  end

  // R3
  stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R1
  stall_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ex_mem_read);
endmodule

// File: rtl/hzc_branch.sv
module hzc_branch
  import hzc_pkg::*;
#(
  parameter int              DATA_W = 32,
  parameter int              ADDR_W = 32,
  parameter logic [OP_W-1:0] BR_OP  = 6'b000100
) (
  input  logic [OP_W-1:0]   dec_op,
  input  logic [IMM_W-1:0]  dec_imm,
  input  logic [ADDR_W-1:0] pc_plus4,
  input  logic [DATA_W-1:0] val_a,
  input  logic [DATA_W-1:0] val_b,
  output logic              take,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - IMM_W - 2;

  logic              is_branch;
  logic              equal;
  logic [ADDR_W-1:0] offset;

  assign is_branch = (dec_op == BR_OP);
  assign equal     = (val_a == val_b);
  assign take      = is_branch && equal;

  generate
    if (EXT_W > 0) begin : g_ext
      assign offset = {{EXT_W{dec_imm[IMM_W-1]}}, dec_imm, 2'b00};
    end else begin : g_trunc
      logic [IMM_W+1:0] wide_off;
      assign wide_off = {dec_imm, 2'b00};
      assign offset   = wide_off[ADDR_W-1:0];
    end
  endgenerate

  assign target = pc_plus4 + offset;
endmodule

// File: rtl/hzc_arbiter.sv
module hzc_arbiter
  import hzc_pkg::*;
(
  input  logic     rst_n,
  input  logic     stall,
  input  logic     take,
  output logic     pc_we,
  output logic     ifid_we,
  output logic     zero_ctrl,
  output logic     flush,
  output npc_sel_e npc_sel
);
  logic redirect;

  // A stall wins over a taken branch: the branch stays in decode and is
  // evaluated again once the hold lifts.
  assign redirect  = rst_n && take && !stall;

  assign pc_we     = !stall;
  assign ifid_we   = !stall;
  assign zero_ctrl = stall;
  assign flush     = redirect;
  assign npc_sel   = redirect ? NPC_REDIRECT : NPC_FALLTHRU;
endmodule

// File: rtl/hzc_ctrl.sv
module hzc_ctrl
  import hzc_pkg::*;
#(
  parameter int              DATA_W = 32,
  parameter int              ADDR_W = 32,
  parameter logic [OP_W-1:0] BR_OP  = 6'b000100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [INSTR_W-1:0]  ifid_instr,
  input  logic [ADDR_W-1:0]   ifid_pc_plus4,
  input  logic                idex_mem_read,
  input  logic [REG_W-1:0]    idex_rt,
  input  logic [DATA_W-1:0]   rdata_a,
  input  logic [DATA_W-1:0]   rdata_b,
  output logic                pc_write_en,
  output logic                ifid_write_en,
  output logic                ctrl_zero_sel,
  output logic                ifid_flush,
  output logic [ADDR_W-1:0]   next_pc,
  output logic                next_pc_sel
);
  dec_word_t dw;
  logic      stall;
  logic      take;
  npc_sel_e  sel_enum;

  assign dw = dec_word_t'(ifid_instr);

  hzc_loaduse u_loaduse (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_src1   (dw.src1),
    .dec_src2   (dw.src2),
    .ex_mem_read(idex_mem_read),
    .ex_dest    (idex_rt),
    .stall      (stall)
  );

  hzc_branch #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .BR_OP (BR_OP)
  ) u_branch (
    .dec_op  (dw.op),
    .dec_imm (dw.imm),
    .pc_plus4(ifid_pc_plus4),
    .val_a   (rdata_a),
    .val_b   (rdata_b),
    .take    (take),
    .target  (next_pc)
  );

  hzc_arbiter u_arbiter (
    .rst_n    (rst_n),
    .stall    (stall),
    .take     (take),
    .pc_we    (pc_write_en),
    .ifid_we  (ifid_write_en),
    .zero_ctrl(ctrl_zero_sel),
    .flush    (ifid_flush),
    .npc_sel  (sel_enum)
  );

  assign next_pc_sel = (sel_enum == NPC_REDIRECT);

  // R2
  hold_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_write_en == ifid_write_en) && (ctrl_zero_sel != pc_write_en));

  // R7
  stall_over_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_zero_sel |-> (!ifid_flush && !next_pc_sel));

  // R6
  flush_with_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush == next_pc_sel);

  // R4
  redirect_needs_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc_sel |-> ((rdata_a == rdata_b) && (ifid_instr[31:26] == BR_OP)));
endmodule

// File: tb/hzc_ctrl_bench.sv
`timescale 1ns/1ps
module hzc_ctrl_bench;
  localparam int DW = 32;
  localparam int AW = 32;

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] pc4;
    logic        mrd;
    logic [4:0]  irt;
    logic [31:0] a;
    logic [31:0] b;
    logic        e_stall;
    logic        e_take;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R1: first source field matches
    '{{6'd0, 5'd3, 5'd7, 16'h0000}, 32'h0000_0100, 1'b1, 5'd3, 32'd1, 32'd2, 1'b1, 1'b0, 4'd1},
    // R1: second source field matches
    '{{6'd0, 5'd4, 5'd9, 16'h0000}, 32'h0000_0100, 1'b1, 5'd9, 32'd1, 32'd2, 1'b1, 1'b0, 4'd1},
    // R2: match but no memory read, so no hold
    '{{6'd0, 5'd4, 5'd9, 16'h0000}, 32'h0000_0100, 1'b0, 5'd4, 32'd1, 32'd2, 1'b0, 1'b0, 4'd2},
    // R2: memory read without a match
    '{{6'd0, 5'd4, 5'd9, 16'h0000}, 32'h0000_0100, 1'b1, 5'd5, 32'd1, 32'd2, 1'b0, 1'b0, 4'd2},
    // R6: taken branch, positive offset
    '{{6'd4, 5'd1, 5'd2, 16'h0010}, 32'h0000_0100, 1'b0, 5'd0, 32'h55, 32'h55, 1'b0, 1'b1, 4'd6},
    // R4: branch with unequal values falls through
    '{{6'd4, 5'd1, 5'd2, 16'h0010}, 32'h0000_0100, 1'b0, 5'd0, 32'h1, 32'h2, 1'b0, 1'b0, 4'd4},
    // R5: negative offset
    '{{6'd4, 5'd1, 5'd2, 16'hFFFE}, 32'h0000_0200, 1'b0, 5'd0, 32'h7, 32'h7, 1'b0, 1'b1, 4'd5},
    // R4: other opcode with equal values never redirects
    '{{6'd0, 5'd1, 5'd2, 16'h0010}, 32'h0000_0100, 1'b0, 5'd0, 32'h9, 32'h9, 1'b0, 1'b0, 4'd4},
    // R7: taken branch with load-use dependency, stall wins
    '{{6'd4, 5'd6, 5'd2, 16'h0004}, 32'h0000_0300, 1'b1, 5'd6, 32'h3, 32'h3, 1'b1, 1'b0, 4'd7},
    // R1: register 0 is not exempt
    '{{6'd0, 5'd0, 5'd8, 16'h0000}, 32'h0000_0100, 1'b1, 5'd0, 32'd1, 32'd2, 1'b1, 1'b0, 4'd1}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [31:0]    ifid_instr = '0;
  logic [AW-1:0]  ifid_pc_plus4 = '0;
  logic           idex_mem_read = 1'b0;
  logic [4:0]     idex_rt = '0;
  logic [DW-1:0]  rdata_a = '0;
  logic [DW-1:0]  rdata_b = '0;
  logic           pc_write_en;
  logic           ifid_write_en;
  logic           ctrl_zero_sel;
  logic           ifid_flush;
  logic [AW-1:0]  next_pc;
  logic           next_pc_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  hzc_ctrl u_hzc_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ifid_instr   (ifid_instr),
    .ifid_pc_plus4(ifid_pc_plus4),
    .idex_mem_read(idex_mem_read),
    .idex_rt      (idex_rt),
    .rdata_a      (rdata_a),
    .rdata_b      (rdata_b),
    .pc_write_en  (pc_write_en),
    .ifid_write_en(ifid_write_en),
    .ctrl_zero_sel(ctrl_zero_sel),
    .ifid_flush   (ifid_flush),
    .next_pc      (next_pc),
    .next_pc_sel  (next_pc_sel)
  );

  function automatic logic [AW-1:0] exp_target(input logic [AW-1:0] pc4,
                                               input logic [15:0] imm);
    logic [AW-1:0] off;
    off = {{(AW-18){imm[15]}}, imm, 2'b00};
    return pc4 + off;
  endfunction

  task automatic drive(input logic [31:0] ins, input logic [31:0] pc4,
                       input logic mrd, input logic [4:0] irt,
                       input logic [31:0] a, input logic [31:0] b);
    ifid_instr    = ins;
    ifid_pc_plus4 = pc4;
    idex_mem_read = mrd;
    idex_rt       = irt;
    rdata_a       = a;
    rdata_b       = b;
  endtask

  task automatic check(input string tag, input logic es, input logic et,
                       input logic [AW-1:0] tgt);
    n_checks++;
    if (ctrl_zero_sel !== es || pc_write_en !== !es || ifid_write_en !== !es ||
        ifid_flush !== et || next_pc_sel !== et || next_pc !== tgt) begin
      n_fail++;
      $display("FAIL %s: got zero=%b pcwe=%b ifwe=%b flush=%b sel=%b npc=%h, expected zero=%b pcwe=%b ifwe=%b flush=%b sel=%b npc=%h",
               tag, ctrl_zero_sel, pc_write_en, ifid_write_en, ifid_flush,
               next_pc_sel, next_pc, es, !es, !es, et, et, tgt);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] ld_ins;
    logic [31:0] br_ins;

    // R8: during reset, a load-use pattern and an equal branch signal nothing
    ld_ins = {6'd4, 5'd3, 5'd3, 16'h0008};
    drive(ld_ins, 32'h40, 1'b1, 5'd3, 32'h5, 32'h5);
    repeat (3) @(negedge clk);
    #1 check("R8 in reset", 1'b0, 1'b0, exp_target(32'h40, 16'h0008));

    // R8: the first cycle after reset can stall
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R8 first cycle after reset", 1'b1, 1'b0, exp_target(32'h40, 16'h0008));

    // R3: same inputs held, the next cycle does not stall; R7: the held branch resolves
    @(negedge clk);
    #1 check("R3/R7 cycle after stall", 1'b0, 1'b1, exp_target(32'h40, 16'h0008));

    // R3: a fresh stall may follow
    @(negedge clk);
    #1 check("R3 stall again", 1'b1, 1'b0, exp_target(32'h40, 16'h0008));

    // Table walk, with an idle cycle in front of each vector
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(32'h0, 32'h0, 1'b0, 5'd0, 32'h0, 32'h1);
      @(negedge clk);
      drive(VECS[i].instr, VECS[i].pc4, VECS[i].mrd, VECS[i].irt,
            VECS[i].a, VECS[i].b);
      #1 check($sformatf("R%0d table vector %0d", VECS[i].req, i),
               VECS[i].e_stall, VECS[i].e_take,
               exp_target(VECS[i].pc4, VECS[i].instr[15:0]));
    end

    // R5: the target wraps around the top of the address space
    @(negedge clk);
    br_ins = {6'd4, 5'd1, 5'd2, 16'h0001};
    drive(br_ins, 32'hFFFF_FFFC, 1'b0, 5'd0, 32'hA, 32'hA);
    #1 check("R5 wrap", 1'b0, 1'b1, 32'h0000_0000);

    // R5: most negative offset
    @(negedge clk);
    br_ins = {6'd4, 5'd1, 5'd2, 16'h8000};
    drive(br_ins, 32'h0004_0000, 1'b0, 5'd0, 32'hA, 32'hB);
    #1 check("R5 min offset", 1'b0, 1'b0, 32'h0002_0000);

    // R6: a taken branch whose execute stage is loading an unrelated register
    @(negedge clk);
    br_ins = {6'd4, 5'd1, 5'd2, 16'h0002};
    drive(br_ins, 32'h0000_1000, 1'b1, 5'd9, 32'hC, 32'hC);
    #1 check("R6 load unrelated", 1'b0, 1'b1, 32'h0000_1008);

    done = 1'b1;
    finish_run();
  end
endmodule